// File: doc/BRIEF.md
# Serial-Loaded DAC Control Front End

This block is the digital input stage of a 12-bit digital-to-analog converter that is written over a three-wire serial link. A host lowers the active-low frame strobe, clocks in a 16-bit word most significant bit first, and raises the strobe again. The upper four bits of the word select an operation and the lower twelve carry a code. A load operation moves the code onto the parallel DAC code output.

The edge of the serial clock that samples data can be changed at run time by command. The serial output always moves on the other edge, so several of these blocks can be chained: each frame's word comes out of the serial output during the next frame. A readback command replaces the word held in the shift path with the current DAC code, so the host can read the code back during the next frame.

The whole block runs in the serial-clock domain, with an asynchronous active-low reset and no oversampling clock.

Top module: `sdac_front`

## Requirements
- R1: After reset `dac_code` is 0, `sdo` is 0, the shift path holds all zeros and data is sampled on the falling edge of `sclk`.
- R2: While `sync_n` is low, each active `sclk` edge shifts `sdin` into a 16-bit shift path, MSB first. The word is decoded at the 16th active edge after `sync_n` falls. Bits 15:12 of the word are the command and bits 11:0 are the data.
- R3: Command 4'b0001 writes bits 11:0 to `dac_code` at the 16th active edge. Command 4'b0000, and any code that has no listed meaning, leaves `dac_code` unchanged.
- R4: Command 4'b1101 selects the rising edge for sampling and 4'b1100 selects the falling edge. The new setting takes effect when `sync_n` rises and applies from the next frame on.
- R5: `sdo` changes only on the `sclk` edge opposite the active one, and only while `sync_n` is low. It then takes the current MSB of the shift path. While `sync_n` is high it holds its value.
- R6: The 16 bits held in the shift path when a frame starts appear on `sdo` during that frame, MSB first. A downstream device that samples at each active edge reads them in order.
- R7: Command 4'b0010 loads the shift path with {4'b0000, `dac_code`} at the 16th active edge. That value is shifted out on `sdo` during the next frame.
- R8: If `sync_n` rises before 16 active edges, `dac_code` and the edge setting stay unchanged, and the next frame counts its bits from zero.
- R9: Active edges after the 16th in one low period of `sync_n` shift nothing and decode nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Frame strobe, active low |
| sdin | input | 1 | Serial data in |
| dac_code | output | 12 | Parallel code for the converter core |
| sdo | output | 1 | Serial data out, for readback and chaining |

## Verification
The embedded assertions check on every active edge that `dac_code` changes only when a load decodes and then to the decoded data. They also check that a readback decode leaves the DAC code in the shift path, and that edges past the 16th leave the shift path alone. The run-time change of sampling edge, the timing of `sdo` on the opposite edge, the order of bits through a chain and the discarding of aborted frames involve the strobe and both clock edges together. Only the bench's reference model shows these, because it follows every half period of `sclk` across frames in both edge settings.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_W = 16;
  localparam int CTRL_W  = 4;
  localparam int DATA_W  = FRAME_W - CTRL_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [CTRL_W-1:0] {
    OP_IDLE  = 4'b0000,
    OP_WRITE = 4'b0001,
    OP_RDBK  = 4'b0010,
    OP_FALL  = 4'b1100,
    OP_RISE  = 4'b1101
  } sdac_op_e;

  function automatic logic [CTRL_W-1:0] op_field(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-1 -: CTRL_W];
  endfunction

  function automatic logic [DATA_W-1:0] data_field(input logic [FRAME_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  function automatic logic [FRAME_W-1:0] rdbk_frame(input logic [DATA_W-1:0] code);
    return {{CTRL_W{1'b0}}, code};
  endfunction
endpackage

// File: rtl/sdac_edge_ctl.sv
module sdac_edge_ctl
  import sdac_pkg::*;
(
  input  logic sclk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic edge_cmd,
  input  logic edge_rise_req,
  output logic act_clk,
  output logic edge_rise
);
  logic want_rise_q;

  // Active edge always appears as a rising edge of act_clk.
  assign act_clk = edge_rise ? sclk : ~sclk;

  always_ff @(posedge act_clk or negedge rst_n) begin
    if (!rst_n)        want_rise_q <= 1'b0;
    else if (edge_cmd) want_rise_q <= edge_rise_req;
  end

  // Setting is committed only at frame end.
  always_ff @(posedge sync_n or negedge rst_n) begin
    if (!rst_n) edge_rise <= 1'b0;
    else        edge_rise <= want_rise_q;
  end
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
(
  input  logic               act_clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic               sdin,
  input  logic [DATA_W-1:0]  dac_code,
  output logic [FRAME_W-1:0] shift_q,
  output logic               load_fire,
  output logic               rdbk_fire,
  output logic               edge_cmd,
  output logic               edge_rise_req,
  output logic [DATA_W-1:0]  load_data
);
  logic               frm_clr;
  logic [CNT_W-1:0]   cnt_q;
  logic               take;
  logic               last;
  logic [FRAME_W-1:0] word_nx;
  logic [CTRL_W-1:0]  op;

  assign frm_clr = !rst_n || sync_n;
  assign take    = !sync_n && (cnt_q != CNT_W'(FRAME_W));
  assign last    = take && (cnt_q == CNT_W'(FRAME_W - 1));
  assign word_nx = {shift_q[FRAME_W-2:0], sdin};
  assign op      = op_field(word_nx);

  assign load_fire     = last && (op == OP_WRITE);
  assign rdbk_fire     = last && (op == OP_RDBK);
  assign edge_cmd      = last && ((op == OP_RISE) || (op == OP_FALL));
  assign edge_rise_req = (op == OP_RISE);
  assign load_data     = data_field(word_nx);

  always_ff @(posedge act_clk or posedge frm_clr) begin
    if (frm_clr)   cnt_q <= '0;
    else if (take) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge act_clk or negedge rst_n) begin
    if (!rst_n)         shift_q <= '0;
    else if (rdbk_fire) shift_q <= rdbk_frame(dac_code);
    else if (take)      shift_q <= word_nx;
  end

  AST_EXTRA_IGNORED: assert property (@(posedge act_clk) disable iff (frm_clr)
    (cnt_q == CNT_W'(FRAME_W)) |=> $stable(shift_q)); // R9

  AST_RDBK_LOADED: assert property (@(posedge act_clk) disable iff (frm_clr)
    rdbk_fire |=> (shift_q == rdbk_frame($past(dac_code)))); // R7
endmodule

// File: rtl/sdac_dac_reg.sv
module sdac_dac_reg
  import sdac_pkg::*;
(
  input  logic              act_clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] dac_q
);
  always_ff @(posedge act_clk or negedge rst_n) begin
    if (!rst_n)         dac_q <= '0;
    else if (load_fire) dac_q <= load_data;
  end

  AST_DAC_LOAD: assert property (@(posedge act_clk) disable iff (!rst_n)
    load_fire |=> (dac_q == $past(load_data))); // R3

  AST_DAC_HOLD: assert property (@(posedge act_clk) disable iff (!rst_n)
    !load_fire |=> $stable(dac_q)); // R8
endmodule

// File: rtl/sdac_sdo.sv
module sdac_sdo
  import sdac_pkg::*;
(
  input  logic act_clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic msb,
  output logic sdo_q
);
  // Opposite edge of the sampling edge.
  always_ff @(negedge act_clk or negedge rst_n) begin
    if (!rst_n)       sdo_q <= 1'b0;
    else if (!sync_n) sdo_q <= msb;
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sdin,
  output logic [DATA_W-1:0] dac_code,
  output logic              sdo
);
  logic               act_clk;
  logic               edge_rise;
  logic [FRAME_W-1:0] shift_q;
  logic               load_fire;
  logic               rdbk_fire;
  logic               edge_cmd;
  logic               edge_rise_req;
  logic [DATA_W-1:0]  load_data;

  sdac_edge_ctl u_edge (
    .sclk(sclk), .rst_n(rst_n), .sync_n(sync_n),
    .edge_cmd(edge_cmd), .edge_rise_req(edge_rise_req),
    .act_clk(act_clk), .edge_rise(edge_rise)
  );

  sdac_frame_rx u_rx (
    .act_clk(act_clk), .rst_n(rst_n), .sync_n(sync_n), .sdin(sdin),
    .dac_code(dac_code), .shift_q(shift_q), .load_fire(load_fire),
    .rdbk_fire(rdbk_fire), .edge_cmd(edge_cmd),
    .edge_rise_req(edge_rise_req), .load_data(load_data)
  );

  sdac_dac_reg u_dac (
    .act_clk(act_clk), .rst_n(rst_n), .load_fire(load_fire),
    .load_data(load_data), .dac_q(dac_code)
  );

  sdac_sdo u_sdo (
    .act_clk(act_clk), .rst_n(rst_n), .sync_n(sync_n),
    .msb(shift_q[FRAME_W-1]), .sdo_q(sdo)
  );
endmodule

// File: tb/test_sdac_front.sv
module test_sdac_front;
  logic clk = 1'b0;
  logic sclk, rst_n, sync_n, sdin;
  logic [11:0] dac_code;
  logic sdo;
  int total = 0, bad = 0;
  logic run_cmp = 1'b0;

  bit    m_q[$];
  int    m_cnt;
  logic [11:0] m_dac;
  logic  m_rise, m_want, m_sdo;

  always #2 clk = ~clk;

  sdac_front i_sdac_front (
    .sclk(sclk), .rst_n(rst_n), .sync_n(sync_n), .sdin(sdin),
    .dac_code(dac_code), .sdo(sdo)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_word();
    logic [15:0] w = '0;
    foreach (m_q[k]) w = {w[14:0], logic'(m_q[k])};
    return w;
  endfunction

  task automatic m_active(input logic b);
    logic [15:0] w;
    if (m_cnt >= 16) return;
    m_q.push_back(b);
    void'(m_q.pop_front());
    m_cnt++;
    if (m_cnt == 16) begin
      w = m_word();
      case (w[15:12])
        4'b0001: m_dac = w[11:0];
        4'b0010: begin
          m_q.delete();
          for (int k = 15; k >= 0; k--) m_q.push_back((k < 12) ? m_dac[k] : 1'b0);
        end
        4'b1101: m_want = 1'b1;
        4'b1100: m_want = 1'b0;
        default: ;
      endcase
    end
  endtask

  // Compared on every clock against the model (R3 code, R5 serial out).
  always @(posedge clk) if (run_cmp) begin
    check("R3 dac_code per cycle", 16'(dac_code), 16'(m_dac));
    check("R5 sdo per cycle", 16'(sdo), 16'(m_sdo));
  end

  task automatic send(input logic [31:0] pat, input int nbits, output logic [15:0] cap);
    logic act_lvl = m_rise;
    cap = '0;
    @(negedge clk); sclk = !act_lvl;
    @(negedge clk); sync_n = 1'b0; sdin = pat[nbits-1];
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i < 16) cap = {cap[14:0], sdo};
      sclk = act_lvl;
      m_active(sdin);
      @(negedge clk);
      sclk = !act_lvl;
      m_sdo = logic'(m_q[0]);
      if (i + 1 < nbits) sdin = pat[nbits-2-i];
    end
    @(negedge clk); sync_n = 1'b1; m_rise = m_want; m_cnt = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] cap;
    sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0; rst_n = 1'b0;
    m_q.delete();
    for (int k = 0; k < 16; k++) m_q.push_back(1'b0);
    m_cnt = 0; m_dac = '0; m_rise = 1'b0; m_want = 1'b0; m_sdo = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    check("R1 reset dac_code", 16'(dac_code), 16'h0);
    check("R1 reset sdo", 16'(sdo), 16'h0);
    run_cmp = 1'b1;

    send(32'h1ABC, 16, cap);
    check("R1 first frame sees zero shift path", cap, 16'h0000);
    check("R2 load on falling edge", 16'(dac_code), 16'h0ABC);
    send(32'h0555, 16, cap);
    check("R6 chain passthrough", cap, 16'h1ABC);
    check("R3 idle op keeps code", 16'(dac_code), 16'h0ABC);
    send(32'h7123, 16, cap);
    check("R3 unlisted op keeps code", 16'(dac_code), 16'h0ABC);
    send(32'h2000, 16, cap);
    send(32'h0000, 16, cap);
    check("R7 readback word", cap, 16'h0ABC);

    send(32'hD000, 16, cap);
    send(32'h1123, 16, cap);
    check("R4 load on rising edge", 16'(dac_code), 16'h0123);
    send(32'h0777, 16, cap);
    check("R6 chain in rising mode", cap, 16'h1123);

    send(32'h1FFF, 10, cap);
    check("R8 aborted frame keeps code", 16'(dac_code), 16'h0123);
    send(32'hC3FF, 12, cap);
    send(32'h1456, 16, cap);
    check("R8 abort keeps edge, count restarts", 16'(dac_code), 16'h0456);

    send(32'h1789F, 20, cap);
    check("R9 extra edges ignored", 16'(dac_code), 16'h0789);
    send(32'hC000, 16, cap);
    check("R9 word unchanged by extra edges", cap, 16'h1789);
    send(32'h1321, 16, cap);
    check("R4 back to falling edge", 16'(dac_code), 16'h0321);
    check("R4 model edge is falling", 16'(m_rise), 16'h0);

    run_cmp = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule